// File: doc/BRIEF.md
# Phase-Accumulator Three-Voice Sound Engine

This block gives a rough model of a classic three-voice square-wave sound generator. It uses phase accumulators, one per generator, that advance at a fixed sample rate. In the intended system the strobe arrives at 12500 Hz, which is one third of a 37500 Hz interrupt rate.

On each sample strobe the block updates five generators: tones A, B and C, the envelope, and the noise source. Each generator adds its own step value to a 24-bit accumulator. A carry out of that add is an overflow event:

- A tone overflow flips that voice's square-wave bit.
- A noise overflow rotates an 8-bit pseudo-random byte.
- An envelope overflow takes the next level from an external table and moves the table index on.

One clock after the strobe, the block mixes each voice into a linear 8-bit level and registers it into four DAC words. Voice B drives two of those DAC words.

The envelope table itself sits outside the block. The block shows the current index on a port and reads the addressed value back on a second port. Any translation of host register writes into step values, masks and levels also happens outside.

Top module: `phase_psg_engine`

## Requirements
- R1: After reset, all four DAC words, all accumulators, the six state bits, the envelope level and the envelope index are 0, and the noise byte holds 8'h96.
- R2: A strobe sampled at clock edge k advances the generators at edge k. The DAC words load at edge k+1 and keep their value at every other edge. Strobes are spaced at least two cycles apart.
- R3: Each generator adds its 24-bit step to its 24-bit accumulator, modulo 2^24, once per strobe. The carry out of bit 23 is that generator's overflow for the tick.
- R4: An overflow of tone A, B or C inverts state bit 0, 1 or 2 respectively.
- R5: A noise overflow rotates the noise byte right by one place, so bit 0 moves into bit 7. If the bit moved out is 1, state bits 3, 4 and 5 all invert together. Those three bits are therefore always equal.
- R6: An envelope overflow loads `envValue` as the envelope level and increments `envIndex` by one, modulo 256.
- R7: A voice uses the current envelope level as its amplitude when its bit in `envSel` is 1 (bit 0 = A, bit 1 = B, bit 2 = C). Otherwise it uses its own level input.
- R8: The mix is computed as follows:
  - `eff = state | mixMask`. Bits 0–2 mask tone A–C and bits 3–5 mask noise A–C; a 1 forces the bit to 1.
  - A voice's result is its amplitude, plus the amplitude once more for each of its tone bit (`eff[v]`) and noise bit (`eff[v+3]`) that is 0.
  - The result is taken modulo 256.
- R9: Voice A is written to DAC 0, voice B to both DAC 1 and DAC 2, and voice C to DAC 3.
- R10: A tone can invert at most once per strobe, so the highest tone is half the sample rate. A step of 24'hFFFFFF inverts the bit on every strobe after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle sample strobe |
| stepToneA | input | 24 | Phase step of tone A |
| stepToneB | input | 24 | Phase step of tone B |
| stepToneC | input | 24 | Phase step of tone C |
| stepEnv | input | 24 | Phase step of the envelope |
| stepNoise | input | 24 | Phase step of the noise source |
| mixMask | input | 6 | Tone (bits 0–2) and noise (bits 3–5) masks |
| levelA | input | 8 | Fixed amplitude of voice A |
| levelB | input | 8 | Fixed amplitude of voice B |
| levelC | input | 8 | Fixed amplitude of voice C |
| envSel | input | 3 | Per-voice envelope select |
| envValue | input | 8 | Table value at `envIndex` |
| envIndex | output | 8 | Envelope table index |
| dac0 | output | 8 | DAC word 0 (voice A) |
| dac1 | output | 8 | DAC word 1 (voice B) |
| dac2 | output | 8 | DAC word 2 (voice B) |
| dac3 | output | 8 | DAC word 3 (voice C) |

## Verification
The assertions assume that `sampleTick` is never high on two consecutive cycles. The DAC-hold and state-hold checks depend on that gap between the advance and the mix load.

The stimulus only raises the strobe for one cycle and then waits two full cycles before sampling. It changes steps, masks and levels only between strobes, at falling edges. The envelope table is modelled in the bench as a pure function of the index, so `envValue` is stable whenever an overflow is taken.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int NUM_VOICE = 3;
  localparam int NUM_GEN   = 5;
  localparam int NUM_DAC   = 4;
  localparam int GEN_ENV   = 3;
  localparam int GEN_NOISE = 4;

  typedef struct packed {
    logic advance;
    logic mixLoad;
  } psgStrobe_t;
endpackage

// File: rtl/psg_ctrl.sv
module psg_ctrl
  import psg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  output psgStrobe_t strobes
);
  logic mixLoadQ;

  always_ff @(posedge clk) begin
    if (!rstN) mixLoadQ <= 1'b0;
    else       mixLoadQ <= sampleTick;
  end

  always_comb begin
    strobes.advance = sampleTick;
    strobes.mixLoad = mixLoadQ;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick);
endmodule

// File: rtl/psg_phase_acc.sv
module psg_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic [ACC_W-1:0] step,
  output logic             overflow
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum      = {1'b0, acc} + {1'b0, step};
  assign overflow = advance & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rstN)        acc <= '0;
    else if (advance) acc <= sum[ACC_W-1:0];
  end

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(acc));
endmodule

// File: rtl/psg_datapath.sv
module psg_datapath
  import psg_pkg::*;
#(
  parameter int         ACC_W      = 24,
  parameter int         DAC_W      = 8,
  parameter int         IDX_W      = 8,
  parameter logic [7:0] NOISE_SEED = 8'h96
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  psgStrobe_t                          strobes,
  input  logic [NUM_GEN-1:0][ACC_W-1:0]       stepVec,
  input  logic [2*NUM_VOICE-1:0]              mixMask,
  input  logic [NUM_VOICE-1:0][DAC_W-1:0]     levelVec,
  input  logic [NUM_VOICE-1:0]                envSel,
  input  logic [DAC_W-1:0]                    envValue,
  output logic [IDX_W-1:0]                    envIndex,
  output logic [NUM_DAC-1:0][DAC_W-1:0]       dacVec
);
  localparam int ST_W = 2 * NUM_VOICE;

  logic [NUM_GEN-1:0]                ovf;
  logic [ST_W-1:0]                   stateBits;
  logic [ST_W-1:0]                   stateNext;
  logic [7:0]                        noiseByte;
  logic [DAC_W-1:0]                  envLevel;
  logic [ST_W-1:0]                   effBits;
  logic [NUM_VOICE-1:0][DAC_W-1:0]   voiceAmp;
  logic [NUM_VOICE-1:0][DAC_W-1:0]   voiceMix;

  for (genvar g = 0; g < NUM_GEN; g++) begin : gen_acc
    psg_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rstN     (rstN),
      .advance  (strobes.advance),
      .step     (stepVec[g]),
      .overflow (ovf[g])
    );
  end

  always_comb begin
    stateNext = stateBits;
    for (int v = 0; v < NUM_VOICE; v++)
      if (ovf[v]) stateNext[v] = ~stateBits[v];
    if (ovf[GEN_NOISE] && noiseByte[0])
      stateNext[ST_W-1:NUM_VOICE] = ~stateBits[ST_W-1:NUM_VOICE];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateBits <= '0;
      noiseByte <= NOISE_SEED;
      envLevel  <= '0;
      envIndex  <= '0;
    end else if (strobes.advance) begin
      stateBits <= stateNext;
      if (ovf[GEN_NOISE]) noiseByte <= {noiseByte[0], noiseByte[7:1]};
      if (ovf[GEN_ENV]) begin
        envLevel <= envValue;
        envIndex <= envIndex + 1'b1;
      end
    end
  end

  assign effBits = stateBits | mixMask;

  always_comb begin
    for (int v = 0; v < NUM_VOICE; v++) begin
      voiceAmp[v] = envSel[v] ? envLevel : levelVec[v];
      voiceMix[v] = voiceAmp[v]
                  + (effBits[v]           ? '0 : voiceAmp[v])
                  + (effBits[v+NUM_VOICE] ? '0 : voiceAmp[v]);
    end
  end

  for (genvar d = 0; d < NUM_DAC; d++) begin : gen_dac
    localparam int SRC = (d == 0) ? 0 : ((d == NUM_DAC-1) ? 2 : 1);
    always_ff @(posedge clk) begin
      if (!rstN)                dacVec[d] <= '0;
      else if (strobes.mixLoad) dacVec[d] <= voiceMix[SRC];
    end
  end

  // R2
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.mixLoad |=> $stable(dacVec));
  // R4
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(stateBits));
  // R5
  noise_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateBits[ST_W-1:NUM_VOICE] == '0 || stateBits[ST_W-1:NUM_VOICE] == '1);
  // R6
  env_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && ovf[GEN_ENV]) |=> envIndex == IDX_W'($past(envIndex) + 1'b1));
  // R9
  dac_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacVec[1] == dacVec[2]);
endmodule

// File: rtl/phase_psg_engine.sv
module phase_psg_engine
  import psg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic [23:0] stepToneA,
  input  logic [23:0] stepToneB,
  input  logic [23:0] stepToneC,
  input  logic [23:0] stepEnv,
  input  logic [23:0] stepNoise,
  input  logic [5:0]  mixMask,
  input  logic [7:0]  levelA,
  input  logic [7:0]  levelB,
  input  logic [7:0]  levelC,
  input  logic [2:0]  envSel,
  input  logic [7:0]  envValue,
  output logic [7:0]  envIndex,
  output logic [7:0]  dac0,
  output logic [7:0]  dac1,
  output logic [7:0]  dac2,
  output logic [7:0]  dac3
);
  psgStrobe_t                  strobes;
  logic [NUM_DAC-1:0][7:0]     dacVec;

  psg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .strobes    (strobes)
  );

  psg_datapath #(.ACC_W(24), .DAC_W(8), .IDX_W(8), .NOISE_SEED(8'h96)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stepVec  ({stepNoise, stepEnv, stepToneC, stepToneB, stepToneA}),
    .mixMask  (mixMask),
    .levelVec ({levelC, levelB, levelA}),
    .envSel   (envSel),
    .envValue (envValue),
    .envIndex (envIndex),
    .dacVec   (dacVec)
  );

  assign dac0 = dacVec[0];
  assign dac1 = dacVec[1];
  assign dac2 = dacVec[2];
  assign dac3 = dacVec[3];
endmodule

// File: tb/phase_psg_engine_tb.sv
`timescale 1ns/1ps
module phase_psg_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b0;
  logic [23:0] stepToneA = '0, stepToneB = '0, stepToneC = '0, stepEnv = '0, stepNoise = '0;
  logic [5:0]  mixMask = 6'h3F;
  logic [7:0]  levelA = '0, levelB = '0, levelC = '0;
  logic [2:0]  envSel = '0;
  logic [7:0]  envValue;
  logic [7:0]  envIndex, dac0, dac1, dac2, dac3;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [23:0] mAcc [5];
  logic [5:0]  mState;
  logic [7:0]  mNoise;
  logic [7:0]  mEnvLvl;
  logic [7:0]  mEnvIdx;

  always #2 clk = ~clk;

  // envelope table modelled as a function of the index
  assign envValue = envIndex * 8'd7 + 8'd3;

  phase_psg_engine u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .stepToneA(stepToneA), .stepToneB(stepToneB), .stepToneC(stepToneC),
    .stepEnv(stepEnv), .stepNoise(stepNoise), .mixMask(mixMask),
    .levelA(levelA), .levelB(levelB), .levelC(levelC), .envSel(envSel),
    .envValue(envValue), .envIndex(envIndex),
    .dac0(dac0), .dac1(dac1), .dac2(dac2), .dac3(dac3)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int voiceExp(input int v);
    logic [5:0] eff;
    int amp, r;
    eff = mState | mixMask;
    amp = envSel[v] ? int'(mEnvLvl) : (v == 0 ? int'(levelA) : v == 1 ? int'(levelB) : int'(levelC));
    r = amp;
    if (!eff[v])   r += amp;
    if (!eff[v+3]) r += amp;
    return r & 255;
  endfunction

  task automatic checkDacs(input string req);
    check({req, "/R9 dac0"}, dac0, voiceExp(0));
    check({req, "/R9 dac1"}, dac1, voiceExp(1));
    check({req, "/R9 dac2"}, dac2, voiceExp(1));
    check({req, "/R9 dac3"}, dac3, voiceExp(2));
  endtask

  // one strobe: advance at edge k, DAC load at edge k+1, sample after
  task automatic doTick();
    logic [24:0] s;
    logic [23:0] stp;
    @(negedge clk) sampleTick = 1'b1;
    for (int g = 0; g < 5; g++) begin
      stp = g == 0 ? stepToneA : g == 1 ? stepToneB : g == 2 ? stepToneC : g == 3 ? stepEnv : stepNoise;
      s = {1'b0, mAcc[g]} + {1'b0, stp};
      mAcc[g] = s[23:0];
      if (s[24]) begin
        if (g < 3) mState[g] = ~mState[g];
        else if (g == 3) begin mEnvLvl = mEnvIdx * 8'd7 + 8'd3; mEnvIdx = mEnvIdx + 8'd1; end
        else begin
          if (mNoise[0]) mState[5:3] = ~mState[5:3];
          mNoise = {mNoise[0], mNoise[7:1]};
        end
      end
    end
    @(negedge clk) sampleTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 dac0", dac0, 0);
    check("R1 dac1", dac1, 0);
    check("R1 dac3", dac3, 0);
    check("R1 envIndex", envIndex, 0);
  endtask

  task automatic testGatedLevels();
    levelA = 8'd10; levelB = 8'd20; levelC = 8'd30; mixMask = 6'h3F;
    doTick();
    check("R8 masked A", dac0, 10);
    check("R9 B dup", dac2, 20);
    checkDacs("R7");
  endtask

  task automatic testToneSquare();
    mixMask = 6'b111_000; stepToneA = 24'h800000;
    for (int i = 0; i < 4; i++) begin
      doTick();
      checkDacs("R4/R3 tone");
    end
    check("R4 tone A back low", dac0, 20);
  endtask

  task automatic testMaxRate();
    stepToneB = 24'hFFFFFF;
    for (int i = 0; i < 5; i++) begin
      doTick();
      checkDacs("R10 max rate");
    end
  endtask

  task automatic testNoise();
    stepToneA = '0; stepToneB = '0; mixMask = 6'b000_111; stepNoise = 24'hFFFFFF;
    for (int i = 0; i < 8; i++) begin
      doTick();
      checkDacs("R5/R1 noise");
    end
  endtask

  task automatic testEnvelope();
    stepNoise = '0; mixMask = 6'h3F; envSel = 3'b101; stepEnv = 24'hFFFFFF;
    for (int i = 0; i < 4; i++) begin
      doTick();
      check("R6 envIndex", envIndex, mEnvIdx);
      checkDacs("R6/R7 env");
    end
  endtask

  task automatic testWrap();
    stepEnv = '0; envSel = '0; levelA = 8'd200; levelB = 8'd200; levelC = 8'd200; mixMask = 6'h00;
    doTick();
    checkDacs("R8 wrap");
  endtask

  task automatic testHold();
    logic [7:0] h0, h1, h3;
    h0 = dac0; h1 = dac1; h3 = dac3;
    levelA = 8'd1; levelB = 8'd2; levelC = 8'd3; mixMask = 6'h15;
    repeat (10) @(negedge clk);
    check("R2 hold dac0", dac0, h0);
    check("R2 hold dac1", dac1, h1);
    check("R2 hold dac3", dac3, h3);
    doTick();
    checkDacs("R2 reload");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < 5; g++) mAcc[g] = '0;
    mState = '0; mNoise = 8'h96; mEnvLvl = '0; mEnvIdx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGatedLevels();
    testToneSquare();
    testMaxRate();
    testNoise();
    testEnvelope();
    testWrap();
    testHold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule